// File: doc/BRIEF.md
# Legacy Region Steering Decoder

This block sits on the host memory request path and decides, for every read or write, whether the request is claimed by local DRAM or handed to the downstream I/O bus. It covers two neighbouring 16 KB firmware-shadow windows just below the 1 MB line. It also covers an optional 1 MB hole that sits directly under the 16 MB mark. Any address outside those regions is claimed by DRAM when it lies below a top-of-memory parameter.

Each shadow window has a 2-bit attribute code that steers reads and writes separately. A window can therefore be fully shadowed, read-only, write-only, or not shadowed at all. The codes live in an 8-bit attribute register. The hole is switched on by one bit in a separate hole register, and a sticky lock input can freeze that bit until the next reset. The routing decision is combinational from the current request and the register contents. A config write takes effect on the request that follows the clock edge that captured it.

Top module: `legacy_steer`

## Requirements
- R1: The lower window covers addresses 0E8000h to 0EBFFFh inclusive, and attribute register bits [1:0] steer it.
- R2: The upper window covers addresses 0EC000h to 0EFFFFh inclusive, and attribute register bits [5:4] steer it.
- R3: Within a window, code 00 sends both reads and writes downstream, and code 11 sends both to DRAM.
- R4: Within a window, code 01 sends reads to DRAM and writes downstream, and code 10 sends writes to DRAM and reads downstream.
- R5: Both registers reset to 00h. In the attribute register (cfgSel=0), bits [7:6] and [3:2] always read 0 and ignore writes. In the hole register (cfgSel=1), only bit 7 is stored and bits [6:0] read 0. A write becomes visible on cfgRdData in the cycle after the capturing edge.
- R6: While hole register bit 7 is 1, every access from F00000h to FFFFFFh inclusive goes downstream. While it is 0, those addresses follow R8.
- R7: From the first cycle holeLock is high until the next reset, writes to the hole register leave bit 7 unchanged, including a write in that first cycle.
- R8: An address outside both windows and outside an enabled hole goes to DRAM when it is below TOP_MEM (default 0400_0000h) and goes downstream otherwise.
- R9: While reqValid is 1, exactly one of routeDram and routeDown is 1, and it is valid in the same cycle. While reqValid is 0, both are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Config write strobe |
| cfgSel | input | 1 | Register select: 0 attribute, 1 hole |
| cfgWrData | input | 8 | Config write data |
| cfgRdData | output | 8 | Contents of the selected register |
| holeLock | input | 1 | Sticky lock for the hole enable bit |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 write, 0 read |
| reqAddr | input | ADDR_W | Request byte address |
| routeDram | output | 1 | Request claimed by DRAM |
| routeDown | output | 1 | Request forwarded downstream |

## Verification
The assertions guard properties that hold on every cycle:
- the one-hot or idle shape of the two route outputs;
- downstream routing above TOP_MEM and inside an enabled hole;
- loading of attribute and hole writes;
- the frozen hole bit once lock has been seen.

Only the bench's sweeps can show that each window decodes the right register field with the right read/write split for all four codes. The same holds for the exact inclusive range edges, one address below and above each edge, the masking of reserved bits, and lock being released by reset alone.

// File: rtl/legacy_steer_pkg.sv
package legacy_steer_pkg;

  localparam int NUM_SEG   = 2;
  localparam int CFG_W     = 8;
  localparam int SEG_PITCH = 4;
  localparam logic [CFG_W-1:0] ATTR_MASK = 8'h33;
  localparam int HOLE_BIT  = 7;

  typedef enum logic [1:0] {
    ATTR_DOWN   = 2'b00,
    ATTR_RDONLY = 2'b01,
    ATTR_WRONLY = 2'b10,
    ATTR_DRAM   = 2'b11
  } attrCode_t;

  typedef struct packed {
    logic [NUM_SEG-1:0] rdDram;
    logic [NUM_SEG-1:0] wrDram;
    logic               holeOn;
  } steerCtl_t;

  function automatic logic codeReadsDram(attrCode_t c);
    case (c)
      ATTR_RDONLY, ATTR_DRAM: return 1'b1;
      default:                return 1'b0;
    endcase
  endfunction

  function automatic logic codeWritesDram(attrCode_t c);
    case (c)
      ATTR_WRONLY, ATTR_DRAM: return 1'b1;
      default:                return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/legacy_steer_ctrl.sv
module legacy_steer_ctrl
  import legacy_steer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic             cfgSel,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             holeLock,
  output logic [CFG_W-1:0] cfgRdData,
  output steerCtl_t        ctl
);

  logic [1:0]         segCode [NUM_SEG];
  logic               holeEn;
  logic               lockSeen;
  logic [NUM_SEG-1:0] rdVec;
  logic [NUM_SEG-1:0] wrVec;
  logic [CFG_W-1:0]   attrImage;
  logic               holeWrOk;

  assign holeWrOk = cfgWrEn && cfgSel && !holeLock && !lockSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SEG; i++) segCode[i] <= 2'b00;
      holeEn   <= 1'b0;
      lockSeen <= 1'b0;
    end else begin
      if (cfgWrEn && !cfgSel) begin
        for (int i = 0; i < NUM_SEG; i++)
          segCode[i] <= cfgWrData[SEG_PITCH*i +: 2];
      end
      if (holeWrOk) holeEn <= cfgWrData[HOLE_BIT];
      lockSeen <= lockSeen | holeLock;
    end
  end

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_strobe
    assign rdVec[i] = codeReadsDram(attrCode_t'(segCode[i]));
    assign wrVec[i] = codeWritesDram(attrCode_t'(segCode[i]));
  end

  always_comb begin
    attrImage = '0;
    for (int i = 0; i < NUM_SEG; i++) attrImage[SEG_PITCH*i +: 2] = segCode[i];
  end

  assign cfgRdData = cfgSel ? {holeEn, {(CFG_W-1){1'b0}}} : attrImage;
  assign ctl = '{rdDram: rdVec, wrDram: wrVec, holeOn: holeEn};

  // R5
  attr_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !cfgSel) |=> (attrImage == ($past(cfgWrData) & ATTR_MASK)));

  // R5
  hole_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    holeWrOk |=> (holeEn == $past(cfgWrData[HOLE_BIT])));

  // R7
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (holeLock || lockSeen) |=> $stable(holeEn));

endmodule

// File: rtl/legacy_steer_decode.sv
module legacy_steer_decode
  import legacy_steer_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] SEG_BASE  = 'h000E_8000,
  parameter logic [ADDR_W-1:0] SEG_SIZE  = 'h0000_4000,
  parameter logic [ADDR_W-1:0] HOLE_BASE = 'h00F0_0000,
  parameter logic [ADDR_W-1:0] HOLE_SIZE = 'h0010_0000,
  parameter logic [ADDR_W:0]   TOP_MEM   = 'h0400_0000
)(
  input  logic              clk,
  input  logic              rstN,
  input  steerCtl_t         ctl,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              routeDram,
  output logic              routeDown
);

  localparam logic [ADDR_W:0] HOLE_LO = {1'b0, HOLE_BASE};
  localparam logic [ADDR_W:0] HOLE_HI = {1'b0, HOLE_BASE} + {1'b0, HOLE_SIZE};

  logic [ADDR_W:0]    addrExt;
  logic [NUM_SEG-1:0] inSeg;
  logic [NUM_SEG-1:0] segDram;
  logic               inHole;
  logic               claimDram;

  assign addrExt = {1'b0, reqAddr};

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
    localparam logic [ADDR_W:0] SEG_LO =
      {1'b0, SEG_BASE} + (ADDR_W+1)'(i) * {1'b0, SEG_SIZE};
    localparam logic [ADDR_W:0] SEG_HI = SEG_LO + {1'b0, SEG_SIZE};
    assign inSeg[i]   = (addrExt >= SEG_LO) && (addrExt < SEG_HI);
    assign segDram[i] = reqWrite ? ctl.wrDram[i] : ctl.rdDram[i];
  end

  assign inHole = (addrExt >= HOLE_LO) && (addrExt < HOLE_HI);

  always_comb begin
    if (|inSeg)                    claimDram = |(inSeg & segDram);
    else if (ctl.holeOn && inHole) claimDram = 1'b0;
    else                           claimDram = addrExt < TOP_MEM;
  end

  assign routeDram = reqValid & claimDram;
  assign routeDown = reqValid & ~claimDram;

  // R9
  route_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> $onehot({routeDram, routeDown}));

  // R9
  route_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> !(routeDram || routeDown));

  // R8
  tom_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (addrExt >= TOP_MEM)) |-> routeDown);

  // R6
  hole_claim_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && ctl.holeOn && (addrExt >= HOLE_LO) && (addrExt < HOLE_HI))
      |-> routeDown);

endmodule

// File: rtl/legacy_steer.sv
module legacy_steer
  import legacy_steer_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] SEG_BASE  = 'h000E_8000,
  parameter logic [ADDR_W-1:0] SEG_SIZE  = 'h0000_4000,
  parameter logic [ADDR_W-1:0] HOLE_BASE = 'h00F0_0000,
  parameter logic [ADDR_W-1:0] HOLE_SIZE = 'h0010_0000,
  parameter logic [ADDR_W:0]   TOP_MEM   = 'h0400_0000
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgSel,
  input  logic [7:0]        cfgWrData,
  output logic [7:0]        cfgRdData,
  input  logic              holeLock,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              routeDram,
  output logic              routeDown
);

  steerCtl_t ctl;

  legacy_steer_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgSel    (cfgSel),
    .cfgWrData (cfgWrData),
    .holeLock  (holeLock),
    .cfgRdData (cfgRdData),
    .ctl       (ctl)
  );

  legacy_steer_decode #(
    .ADDR_W    (ADDR_W),
    .SEG_BASE  (SEG_BASE),
    .SEG_SIZE  (SEG_SIZE),
    .HOLE_BASE (HOLE_BASE),
    .HOLE_SIZE (HOLE_SIZE),
    .TOP_MEM   (TOP_MEM)
  ) u_decode (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .reqAddr   (reqAddr),
    .routeDram (routeDram),
    .routeDown (routeDown)
  );

endmodule

// File: tb/legacy_steer_test.sv
module legacy_steer_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic        cfgSel = 1'b0;
  logic [7:0]  cfgWrData = '0;
  logic [7:0]  cfgRdData;
  logic        holeLock = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        routeDram;
  logic        routeDown;

  int  applied = 0;
  int  miscompares = 0;
  bit  done = 1'b0;

  localparam logic [31:0] TOM = 32'h0400_0000;

  always #2 clk = ~clk;

  legacy_steer uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .holeLock(holeLock),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .routeDram(routeDram), .routeDown(routeDown)
  );

  function automatic bit expDram(logic [31:0] a, bit wr, logic [7:0] attr, bit hole);
    logic [1:0] code;
    if (a >= 32'hE8000 && a <= 32'hEBFFF) begin
      code = attr[1:0];
      return wr ? code[1] : code[0];
    end
    if (a >= 32'hEC000 && a <= 32'hEFFFF) begin
      code = attr[5:4];
      return wr ? code[1] : code[0];
    end
    if (hole && a >= 32'hF00000 && a <= 32'hFFFFFF) return 1'b0;
    return a < TOM;
  endfunction

  function automatic string tagFor(logic [31:0] a, logic [7:0] attr);
    logic [1:0] code;
    if (a >= 32'hE8000 && a <= 32'hEBFFF) begin
      code = attr[1:0];
      return (code == 2'b00 || code == 2'b11) ? "R1/R3" : "R1/R4";
    end
    if (a >= 32'hEC000 && a <= 32'hEFFFF) begin
      code = attr[5:4];
      return (code == 2'b00 || code == 2'b11) ? "R2/R3" : "R2/R4";
    end
    return "R1/R2/R8";
  endfunction

  task automatic cfgWrite(bit sel, logic [7:0] d, bit lock);
    @(negedge clk);
    cfgSel = sel; cfgWrData = d; cfgWrEn = 1'b1; holeLock = lock;
    @(negedge clk);
    cfgWrEn = 1'b0; holeLock = 1'b0;
  endtask

  task automatic checkRead(bit sel, logic [7:0] exp, string req);
    @(negedge clk);
    cfgSel = sel;
    #1;
    applied++;
    if (cfgRdData !== exp) begin
      miscompares++;
      $display("FAIL %s cfgRdData sel=%0d actual=%02h expected=%02h", req, sel, cfgRdData, exp);
    end
  endtask

  task automatic probe(logic [31:0] a, bit wr, bit exp, string req);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a;
    #1;
    applied++;
    if (routeDram !== exp || routeDown !== !exp) begin
      miscompares++;
      $display("FAIL %s addr=%08h wr=%0d actual dram/down=%0b%0b expected=%0b%0b",
               req, a, wr, routeDram, routeDown, exp, !exp);
    end
    reqValid = 1'b0;
  endtask

  logic [31:0] segAddrs [8] = '{32'hE7FFF, 32'hE8000, 32'hEA123, 32'hEBFFF,
                                32'hEC000, 32'hEDABC, 32'hEFFFF, 32'hF0000};
  logic [31:0] holeAddrs [6] = '{32'hEFFFFF, 32'hF00000, 32'hF81234,
                                 32'hFFFFFF, 32'h1000000, 32'h0};

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R5 reset state of both registers
    checkRead(1'b0, 8'h00, "R5");
    checkRead(1'b1, 8'h00, "R5");

    // R9 idle request drives neither output
    @(negedge clk);
    reqValid = 1'b0; reqAddr = 32'hE8000;
    #1;
    applied++;
    if (routeDram !== 1'b0 || routeDown !== 1'b0) begin
      miscompares++;
      $display("FAIL R9 idle actual=%0b%0b expected=00", routeDram, routeDown);
    end

    // R1 R2 R3 R4 R5: every code pair, reserved bits set in the written data
    for (int lo = 0; lo < 4; lo++) begin
      for (int hi = 0; hi < 4; hi++) begin
        logic [7:0] wdat;
        logic [7:0] attr;
        wdat = {2'b11, 2'(hi), 2'b11, 2'(lo)};
        attr = {2'b00, 2'(hi), 2'b00, 2'(lo)};
        cfgWrite(1'b0, wdat, 1'b0);
        checkRead(1'b0, attr, "R5");
        for (int k = 0; k < 8; k++) begin
          for (int w = 0; w < 2; w++) begin
            probe(segAddrs[k], w[0], expDram(segAddrs[k], w[0], attr, 1'b0),
                  tagFor(segAddrs[k], attr));
          end
        end
      end
    end

    // R6 hole off then on, reserved hole bits ignored
    cfgWrite(1'b0, 8'h00, 1'b0);
    for (int k = 0; k < 6; k++)
      probe(holeAddrs[k], 1'b0, expDram(holeAddrs[k], 1'b0, 8'h00, 1'b0), "R6");
    cfgWrite(1'b1, 8'hFF, 1'b0);
    checkRead(1'b1, 8'h80, "R5");
    for (int k = 0; k < 6; k++)
      for (int w = 0; w < 2; w++)
        probe(holeAddrs[k], w[0], expDram(holeAddrs[k], w[0], 8'h00, 1'b1), "R6");

    // R8 top-of-memory boundary
    probe(TOM - 1, 1'b0, 1'b1, "R8");
    probe(TOM, 1'b1, 1'b0, "R8");
    probe(32'hFFFF_FFFF, 1'b0, 1'b0, "R8");

    // R7 write in the lock cycle is dropped, later writes also dropped
    cfgWrite(1'b1, 8'h00, 1'b1);
    checkRead(1'b1, 8'h80, "R7");
    cfgWrite(1'b1, 8'h00, 1'b0);
    checkRead(1'b1, 8'h80, "R7");
    probe(32'hF40000, 1'b0, 1'b0, "R7");
    // R7 attribute register unaffected by lock
    cfgWrite(1'b0, 8'h33, 1'b0);
    checkRead(1'b0, 8'h33, "R7");

    // R7 reset releases lock and clears registers
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk); rstN = 1'b1;
    checkRead(1'b1, 8'h00, "R5");
    checkRead(1'b0, 8'h00, "R5");
    probe(32'hF40000, 1'b0, 1'b1, "R6");
    cfgWrite(1'b1, 8'h80, 1'b0);
    checkRead(1'b1, 8'h80, "R7");
    cfgWrite(1'b1, 8'h00, 1'b0);
    checkRead(1'b1, 8'h00, "R7");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

endmodule